// File: doc/BRIEF.md
# Ring-Buffer FIFO with Threshold Status

This block is a single-clock first-in, first-out queue. A writer pushes words with a write strobe, and a reader pops them in arrival order with a read strobe. The storage is a register array that the logic treats as a closed ring. A write pointer and a read pointer move around that ring. Each pointer carries one extra wrap bit, so the block can tell a full ring from an empty one using the pointers alone.

Besides the full and empty flags, the block reports its current occupancy. It also raises a low-fill flag when the occupancy is at or below a threshold. The threshold is an input and can change at any time. A write attempted while the queue is full is dropped, and so is a read attempted while it is empty. Each of these misuses sets a sticky error bit, and the error bits stay set until the clear input is pulsed. A typical use is rate matching: a bursty producer fills the queue, and a steady consumer drains it. The producer starts a new burst whenever the low-fill flag rises.

Top module: `rbq_fifo`

## Requirements
- R1: While reset is held and in the first cycle after it, empty=1, full=0, level=0, low_flag=(0 <= low_thresh), rd_valid=0, rd_data=0, overflow_err=0 and underflow_err=0.
- R2: Words are read out in the order they were accepted. Each accepted word is returned by exactly one accepted read, including after the pointers have wrapped around the ring many times.
- R3: After DEPTH accepted writes with no reads, full=1. A write strobe while full=1 is dropped: level stays at DEPTH, and the dropped word never appears at rd_data.
- R4: When the last stored word is read, empty=1. A read strobe while empty=1 is not accepted: rd_valid stays 0 in the next cycle and rd_data keeps its previous value.
- R5: level equals the number of accepted writes minus the number of accepted reads, and it updates in the cycle after the strobes. A read and a write in the same cycle on a queue that is neither empty nor full leave level unchanged.
- R6: After an accepted read, rd_valid is 1 for exactly the next cycle, and the word read is on rd_data in that cycle. rd_data then holds until the next accepted read.
- R7: low_flag is 1 exactly when level <= low_thresh, with both compared as unsigned numbers. It follows changes to low_thresh in the same cycle.
- R8: In the cycle after a write strobe with full=1, overflow_err is 1. It stays 1 until a cycle in which err_clear=1 and no new overflow occurs; it is 0 from the cycle after that one.
- R9: In the cycle after a read strobe with empty=1, underflow_err is 1. It stays 1 until a cycle in which err_clear=1 and no new underflow occurs; it is 0 from the cycle after that one.
- R10: full and empty are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Word to enqueue |
| full | output | 1 | Queue holds DEPTH words |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Registered word from the last accepted read |
| rd_valid | output | 1 | rd_data was loaded by a read in the previous cycle |
| empty | output | 1 | Queue holds no words |
| level | output | $clog2(DEPTH)+1 | Number of words stored |
| low_thresh | input | $clog2(DEPTH)+1 | Low-fill threshold |
| low_flag | output | 1 | level is at or below low_thresh |
| err_clear | input | 1 | Clears the sticky error bits |
| overflow_err | output | 1 | Sticky: write attempted while full |
| underflow_err | output | 1 | Sticky: read attempted while empty |

## Verification
The clocked properties assume that the strobes, the data, the threshold and the clear input are known values that change only between rising edges. They also assume that reset is applied synchronously at the start of the run. The bench meets this by driving every input on the falling edge and holding reset low across several edges before releasing it. Within those limits the stimulus is left free. It writes into a full queue, reads from an empty one, strobes both together at every fill level, and changes the threshold and the clear input in arbitrary cycles. This makes each property's antecedent occur often.

// File: rtl/rbq_pkg.sv
package rbq_pkg;

   // Selects how the low-fill flag compares the occupancy to the threshold.
   typedef enum logic {
      THR_STRICT = 1'b0,   // flag when level <  threshold
      THR_INCL   = 1'b1    // flag when level <= threshold
   } thr_mode_e;

   // Address width needed for a ring of the given depth.
   function automatic int unsigned ring_aw(input int unsigned depth);
      return (depth < 2) ? 1 : $clog2(depth);
   endfunction

endpackage

// File: rtl/rbq_ptr.sv
module rbq_ptr #(
   parameter int unsigned AW = 3
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        adv,
   output logic [AW:0] ptr
);

   // The top bit flips each time the address bits roll over the ring end.
   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr <= '0;
      else if (adv)
         ptr <= ptr + 1'b1;
   end

endmodule

// File: rtl/rbq_store.sv
module rbq_store #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned AW     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid
);

   logic [DATA_W-1:0] rows [DEPTH];

   // One register per ring slot, each loaded only when addressed.
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [DATA_W-1:0] slot_q;
      always_ff @(posedge clk) begin
         if (we && (waddr == AW'(i)))
            slot_q <= wdata;
      end
      assign rows[i] = slot_q;
   end

   // Registered read port: output moves only on an accepted read.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata  <= '0;
         rvalid <= 1'b0;
      end else begin
         rvalid <= re;
         if (re)
            rdata <= rows[raddr];
      end
   end

   // R6: output data may change only in a cycle flagged valid
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !re |=> $stable(rdata)); // R6

endmodule

// File: rtl/rbq_status.sv
module rbq_status
   import rbq_pkg::*;
#(
   parameter int unsigned DEPTH    = 8,
   parameter int unsigned AW       = 3,
   parameter thr_mode_e   THR_MODE = THR_INCL
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [AW:0] wr_ptr,
   input  logic [AW:0] rd_ptr,
   input  logic        wr_req,
   input  logic        rd_req,
   input  logic        err_clear,
   input  logic [AW:0] thresh,
   output logic        full,
   output logic        empty,
   output logic [AW:0] level,
   output logic        low_flag,
   output logic        ovf_err,
   output logic        udf_err
);

   logic same_addr, same_wrap;

   assign same_addr = (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
   assign same_wrap = (wr_ptr[AW] == rd_ptr[AW]);
   assign empty     = same_addr &&  same_wrap;
   assign full      = same_addr && !same_wrap;
   assign level     = wr_ptr - rd_ptr;

   if (THR_MODE == THR_INCL) begin : g_thr_incl
      assign low_flag = (level <= thresh);
   end else begin : g_thr_strict
      assign low_flag = (level < thresh);
   end

   // Sticky misuse bits; a new event wins over a clear in the same cycle.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovf_err <= 1'b0;
         udf_err <= 1'b0;
      end else begin
         if (wr_req && full)
            ovf_err <= 1'b1;
         else if (err_clear)
            ovf_err <= 1'b0;
         if (rd_req && empty)
            udf_err <= 1'b1;
         else if (err_clear)
            udf_err <= 1'b0;
      end
   end

   AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty)); // R10
   AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      level <= (AW+1)'(DEPTH)); // R5
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_err && !err_clear) |=> ovf_err); // R8
   AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (udf_err && !err_clear) |=> udf_err); // R9

endmodule

// File: rtl/rbq_fifo.sv
module rbq_fifo
   import rbq_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned DEPTH    = 8,
   parameter thr_mode_e   THR_MODE = THR_INCL,
   localparam int unsigned AW      = ring_aw(DEPTH),
   localparam int unsigned CNT_W   = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              full,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              empty,
   output logic [CNT_W-1:0]  level,
   input  logic [CNT_W-1:0]  low_thresh,
   output logic              low_flag,
   input  logic              err_clear,
   output logic              overflow_err,
   output logic              underflow_err
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rbq_fifo: DEPTH must be a power of two of at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("rbq_fifo: DATA_W must be at least 1");
   end

   logic [AW:0] wr_ptr, rd_ptr;
   logic        push, pop;

   assign push = wr_en && !full;
   assign pop  = rd_en && !empty;

   rbq_ptr #(.AW(AW)) u_wr_ptr (
      .clk(clk), .rst_n(rst_n), .adv(push), .ptr(wr_ptr)
   );

   rbq_ptr #(.AW(AW)) u_rd_ptr (
      .clk(clk), .rst_n(rst_n), .adv(pop), .ptr(rd_ptr)
   );

   rbq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (push),
      .waddr (wr_ptr[AW-1:0]),
      .wdata (wr_data),
      .re    (pop),
      .raddr (rd_ptr[AW-1:0]),
      .rdata (rd_data),
      .rvalid(rd_valid)
   );

   rbq_status #(.DEPTH(DEPTH), .AW(AW), .THR_MODE(THR_MODE)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ptr   (wr_ptr),
      .rd_ptr   (rd_ptr),
      .wr_req   (wr_en),
      .rd_req   (rd_en),
      .err_clear(err_clear),
      .thresh   (low_thresh),
      .full     (full),
      .empty    (empty),
      .level    (level),
      .low_flag (low_flag),
      .ovf_err  (overflow_err),
      .udf_err  (underflow_err)
   );

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full) |=> overflow_err); // R8
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && empty) |=> underflow_err); // R9
   AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !rd_en) |=> (full && level == CNT_W'(DEPTH))); // R3
   AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && !wr_en) |=> (empty && !rd_valid)); // R4
   AST_RD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !empty) |=> rd_valid); // R6
   AST_LEVEL_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rd_en && !full && !empty) |=> $stable(level)); // R5
   AST_LEVEL_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !full && !rd_en) |=> (level == CNT_W'($past(level) + 1'b1))); // R5

endmodule

// File: tb/rbq_fifo_bench.sv
module rbq_fifo_bench;

   localparam int DATA_W = 8;
   localparam int DEPTH  = 8;
   localparam int CNT_W  = $clog2(DEPTH) + 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0, rd_en = 1'b0, err_clear = 1'b0;
   logic [DATA_W-1:0] wr_data = '0;
   logic [CNT_W-1:0]  low_thresh = '0;
   logic              full, empty, rd_valid, low_flag, overflow_err, underflow_err;
   logic [DATA_W-1:0] rd_data;
   logic [CNT_W-1:0]  level;

   always #5 clk = ~clk;

   rbq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rbq_fifo (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .full(full),
      .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .empty(empty),
      .level(level), .low_thresh(low_thresh), .low_flag(low_flag),
      .err_clear(err_clear), .overflow_err(overflow_err),
      .underflow_err(underflow_err)
   );

   int n_chk = 0;
   int n_fail = 0;

   // Behavioural reference state
   int q[$];
   int m_rd_data = 0;
   bit m_rd_valid = 0;
   bit m_ovf = 0;
   bit m_udf = 0;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   task automatic compare_all();
      chk("R4 empty", int'(empty), int'(q.size() == 0));
      chk("R3 full", int'(full), int'(q.size() == DEPTH));
      chk("R5 level", int'(level), q.size());
      chk("R7 low_flag", int'(low_flag), int'(q.size() <= int'(low_thresh)));
      chk("R6 rd_valid", int'(rd_valid), int'(m_rd_valid));
      if (m_rd_valid) chk("R2 rd_data", int'(rd_data), m_rd_data);
      else            chk("R4 rd_data held", int'(rd_data), m_rd_data);
      chk("R8 overflow_err", int'(overflow_err), int'(m_ovf));
      chk("R9 underflow_err", int'(underflow_err), int'(m_udf));
      chk("R10 full/empty exclusive", int'(full && empty), 0);
   endtask

   // Inputs are already set; advance one edge, update the model, compare.
   task automatic step();
      bit was_full, was_empty;
      @(posedge clk);
      was_full  = (q.size() == DEPTH);
      was_empty = (q.size() == 0);
      m_rd_valid = 0;
      if (rd_en && !was_empty) begin
         m_rd_data  = q.pop_front();
         m_rd_valid = 1;
      end
      if (wr_en && !was_full) q.push_back(int'(wr_data));
      if (wr_en && was_full) m_ovf = 1;
      else if (err_clear)    m_ovf = 0;
      if (rd_en && was_empty) m_udf = 1;
      else if (err_clear)     m_udf = 0;
      @(negedge clk);
      compare_all();
   endtask

   task automatic drive(input bit w, input int d, input bit r, input int t, input bit c);
      wr_en = w; wr_data = DATA_W'(d); rd_en = r;
      low_thresh = CNT_W'(t); err_clear = c;
      step();
   endtask

   initial begin
      #(200000 * 10);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int seq;
      seq = 1;
      low_thresh = CNT_W'(2);
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: outputs during reset
      chk("R1 empty", int'(empty), 1);
      chk("R1 full", int'(full), 0);
      chk("R1 level", int'(level), 0);
      chk("R1 rd_valid", int'(rd_valid), 0);
      chk("R1 rd_data", int'(rd_data), 0);
      chk("R1 errors", int'(overflow_err) + int'(underflow_err), 0);
      chk("R1 low_flag", int'(low_flag), 1);
      rst_n = 1'b1;
      drive(0, 0, 0, 0, 0);
      chk("R1 empty after release", int'(empty), 1);

      // R3: fill, then write into a full queue; R7 threshold swept
      for (int i = 0; i < DEPTH; i++) begin
         drive(1, seq, 0, i % (DEPTH + 1), 0);
         seq++;
      end
      chk("R3 full after DEPTH writes", int'(full), 1);
      drive(1, 8'hEE, 0, DEPTH, 0);
      chk("R8 overflow set", int'(overflow_err), 1);
      drive(0, 0, 0, DEPTH, 0);
      chk("R8 overflow sticky", int'(overflow_err), 1);
      drive(1, 8'hEF, 0, 3, 1);
      chk("R8 set wins over clear", int'(overflow_err), 1);
      drive(0, 0, 0, 3, 1);
      chk("R8 cleared", int'(overflow_err), 0);

      // R5: simultaneous read and write when full: write is dropped
      drive(1, 8'hEA, 1, 3, 0);
      chk("R3 write dropped while full", int'(level), DEPTH - 1);

      // R2/R4: drain, then read from empty
      while (q.size() > 0) drive(0, 0, 1, 4, 0);
      chk("R4 empty after drain", int'(empty), 1);
      drive(0, 0, 1, 0, 0);
      chk("R9 underflow set", int'(underflow_err), 1);
      chk("R4 no valid on empty read", int'(rd_valid), 0);
      drive(1, 8'h5A, 1, 0, 1);
      chk("R9 set wins over clear", int'(underflow_err), 1);
      drive(0, 0, 0, 0, 1);
      chk("R9 cleared", int'(underflow_err), 0);

      // R5: balanced traffic at a middle level
      drive(1, 8'h11, 0, 2, 0);
      drive(1, 8'h22, 0, 2, 0);
      for (int i = 0; i < 20; i++) begin
         drive(1, seq, 1, 2, 0);
         seq++;
      end
      chk("R5 level steady under balanced traffic", int'(level), 3);

      // R2 wrap and mixed traffic; R7 with a changing threshold
      for (int i = 0; i < 4000; i++) begin
         drive(($urandom_range(0, 99) < 55), int'($urandom_range(0, 255)),
               ($urandom_range(0, 99) < 50), int'($urandom_range(0, DEPTH + 1)),
               ($urandom_range(0, 99) < 5));
      end
      while (q.size() > 0) drive(0, 0, 1, 1, 0);
      drive(0, 0, 0, 0, 1);
      finish_run();
   end

endmodule